// File: doc/BRIEF.md
# IPv4 Hop-Limit Decrement with Incremental Checksum Patch

This block takes the time-to-live byte, the protocol byte beside it, and the header checksum of one IPv4 header. It returns the time-to-live reduced by one and a checksum corrected for that single change. The checksum is never summed again over the whole header. The correction runs on a 16-bit datapath in one's complement arithmetic with end-around carry. The formula is HC' = ~(~HC + ~m + m'), where m is the old 16-bit word {ttl, protocol} and m' is the new one. Because the time-to-live is the high byte of that word, the word drops by 0x0100.

A forwarding pipeline places the block after header field extraction. Fields enter through a valid/ready handshake. The results appear one cycle later on a registered valid/ready output, together with a flag that marks a header whose time-to-live has run out. Such a header goes through unchanged so that later logic can drop it or report it.

Top module: `ipv4_ttl_patch`

## Requirements
- R1: When an accepted time-to-live is 2 or more, the output time-to-live equals the input minus one.
- R2: For a non-expired header, the output checksum equals a full one's complement recomputation of the header with the new time-to-live. The time-to-live is the high byte and the protocol the low byte of its 16-bit word.
- R3: A carry out of bit 15 during the one's complement addition is added back into bit 0. Examples: input checksum 0x0000 gives 0x0100, 0x0100 gives 0x0200, 0x00FF gives 0x01FF, and 0xFF00 gives 0x0001.
- R4: An accepted time-to-live of 0 or 1 sets the expired flag to 1. In that case the time-to-live and the checksum pass through unchanged. Otherwise the flag is 0.
- R5: The protocol byte passes through unchanged in every case.
- R6: While out_valid is 1 and out_ready is 0, every output field holds its value and in_ready is 0.
- R7: An input is accepted on a rising edge where in_valid and in_ready are both 1. Its result is on the outputs with out_valid at 1 after that edge. Exactly one result is produced per accepted input.
- R8: During reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input fields are present |
| in_ready | output | 1 | Block can take input this cycle |
| in_ttl | input | 8 | Incoming time-to-live |
| in_proto | input | 8 | Protocol byte sharing the time-to-live word |
| in_csum | input | 16 | Incoming header checksum |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| out_ttl | output | 8 | Updated time-to-live |
| out_proto | output | 8 | Protocol byte, unchanged |
| out_csum | output | 16 | Patched checksum |
| out_expired | output | 1 | Time-to-live was 0 or 1 at input |

## Verification
Only one register stage holds state, so any fault shows at the ports one cycle after the input that caused it. A wrong fold or a wrong operand shows as a checksum that disagrees with the full recomputation over the reference header on that same result. A wrong hold or handshake state shows as a changed field during a stall, or as a missing or doubled out_valid, within one cycle of the stall or of its release.

// File: rtl/ttl_patch_pkg.sv
// Shared field widths and the bundle that moves through the block.
// Assumes the field widths of an IPv4 header word: TTL high byte, protocol low byte.
package ttl_patch_pkg;
    localparam int unsigned TTL_W  = 8;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned AUX_W  = WORD_W - TTL_W;

    typedef struct packed {
        logic [TTL_W-1:0]  ttl;
        logic [AUX_W-1:0]  proto;
        logic [WORD_W-1:0] csum;
    } hdr_fields_t;

    typedef struct packed {
        hdr_fields_t f;
        logic        expired;
    } patch_result_t;
endpackage

// File: rtl/oc_adder.sv
// One's complement adder of width W with end-around carry.
// Assumes nothing about its operands; the folded sum cannot carry a second time.
module oc_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0] raw;

    // Binary sum, then fold the carry out of the top bit into bit 0.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/ttl_patch_core.sv
// Combinational TTL decrement and incremental checksum patch.
// Assumes the TTL is the high byte of its 16-bit word; at or below EXPIRE_LIMIT the fields pass unchanged.
module ttl_patch_core
    import ttl_patch_pkg::*;
#(
    parameter int unsigned EXPIRE_LIMIT = 1
) (
    input  hdr_fields_t   hdr_i,
    output patch_result_t res_o
);
    localparam logic [TTL_W-1:0] LIMIT = TTL_W'(EXPIRE_LIMIT);

    logic [WORD_W-1:0] word_old, word_new, delta, sum_new;
    logic [TTL_W-1:0]  ttl_dec;
    logic              is_expired;

    // Build the old and new header words around the TTL.
    always_comb begin
        ttl_dec  = hdr_i.ttl - TTL_W'(1);
        word_old = {hdr_i.ttl, hdr_i.proto};
        word_new = {ttl_dec, hdr_i.proto};
    end

    // ~m + m' in one's complement.
    oc_adder #(.W(WORD_W)) u_delta (
        .a (~word_old),
        .b (word_new),
        .s (delta)
    );

    // ~HC + (~m + m') in one's complement.
    oc_adder #(.W(WORD_W)) u_sum (
        .a (~hdr_i.csum),
        .b (delta),
        .s (sum_new)
    );

    // Pick the patched or the untouched fields.
    always_comb begin
        is_expired    = (hdr_i.ttl <= LIMIT);
        res_o.expired = is_expired;
        res_o.f.proto = hdr_i.proto;
        if (is_expired) begin
            res_o.f.ttl  = hdr_i.ttl;
            res_o.f.csum = hdr_i.csum;
        end else begin
            res_o.f.ttl  = ttl_dec;
            res_o.f.csum = ~sum_new;
        end
    end
endmodule

// File: rtl/ttl_patch_stage.sv
// Single output register with valid/ready flow control.
// Assumes the upstream holds its data while it is not accepted; the register holds while stalled.
module ttl_patch_stage
    import ttl_patch_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  patch_result_t up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output patch_result_t dn_data
);
    logic take;

    // Accept when empty or when the held result leaves this cycle.
    always_comb begin
        up_ready = !dn_valid || dn_ready;
        take     = up_valid && up_ready;
    end

    // Valid flag: set on accept, cleared when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n)        dn_valid <= 1'b0;
        else if (up_ready) dn_valid <= up_valid;
    end

    // Data register: loads only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)    dn_data <= '0;
        else if (take) dn_data <= up_data;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R6

    AST_ONE_PER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && !up_valid) |=> !dn_valid); // R7
endmodule

// File: rtl/ipv4_ttl_patch.sv
// Top: TTL decrement with one's complement checksum patch, one register stage.
// Assumes the fields arrive already extracted from the header.
module ipv4_ttl_patch
    import ttl_patch_pkg::*;
#(
    parameter int unsigned EXPIRE_LIMIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TTL_W-1:0]  in_ttl,
    input  logic [AUX_W-1:0]  in_proto,
    input  logic [WORD_W-1:0] in_csum,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TTL_W-1:0]  out_ttl,
    output logic [AUX_W-1:0]  out_proto,
    output logic [WORD_W-1:0] out_csum,
    output logic              out_expired
);
    localparam logic [TTL_W-1:0] LIMIT = TTL_W'(EXPIRE_LIMIT);

    hdr_fields_t   hdr_in;
    patch_result_t res_comb, res_q;
    logic          acc;

    // Bundle the input fields.
    always_comb begin
        hdr_in.ttl   = in_ttl;
        hdr_in.proto = in_proto;
        hdr_in.csum  = in_csum;
    end

    ttl_patch_core #(.EXPIRE_LIMIT(EXPIRE_LIMIT)) u_core (
        .hdr_i (hdr_in),
        .res_o (res_comb)
    );

    ttl_patch_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (res_comb),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (res_q)
    );

    // Unbundle the registered result onto the ports.
    always_comb begin
        out_ttl     = res_q.f.ttl;
        out_proto   = res_q.f.proto;
        out_csum    = res_q.f.csum;
        out_expired = res_q.expired;
        acc         = in_valid && in_ready;
    end

    AST_TTL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_ttl > LIMIT) |=> (out_valid && !out_expired && out_ttl == $past(in_ttl) - 8'd1)); // R1

    AST_CSUM_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_ttl > LIMIT && in_csum == 16'h0000) |=> (out_csum == 16'h0100)); // R3

    AST_EXPIRED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_ttl <= LIMIT) |=> (out_expired && out_ttl == $past(in_ttl) && out_csum == $past(in_csum))); // R4

    AST_PROTO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_proto == $past(in_proto))); // R5
endmodule

// File: tb/ipv4_ttl_patch_bench.sv
module ipv4_ttl_patch_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, out_valid, out_ready, out_expired;
    logic [7:0]  in_ttl, in_proto, out_ttl, out_proto;
    logic [15:0] in_csum, out_csum;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    ipv4_ttl_patch u_ipv4_ttl_patch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ttl(in_ttl), .in_proto(in_proto), .in_csum(in_csum),
        .out_valid(out_valid), .out_ready(out_ready), .out_ttl(out_ttl),
        .out_proto(out_proto), .out_csum(out_csum), .out_expired(out_expired)
    );

    // {ttl, proto, seed for the other header words}
    localparam logic [31:0] VEC [10] = '{
        32'h64_06_1234, 32'h40_11_abcd, 32'hff_01_0000, 32'h02_06_ffff,
        32'h80_06_5a5a, 32'h01_11_7777, 32'h00_06_4321, 32'h03_32_0f0f,
        32'h11_06_8001, 32'hc8_2f_fffe };

    function automatic logic [15:0] full_csum(logic [7:0] ttl, logic [7:0] pr, logic [15:0] sd);
        logic [31:0] acc;
        logic [15:0] w2, w7;
        w2  = sd * 16'd3;
        w7  = sd + 16'h0101;
        acc = 32'h4500 + {16'h0, 16'h0054 ^ sd} + {16'h0, w2} + 32'h4000
            + {16'h0, ttl, pr} + {16'h0, sd ^ 16'hc0a8} + {16'h0, w7}
            + {16'h0, ~sd} + {16'h0, sd[7:0], sd[15:8]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        return ~acc[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] t, input logic [7:0] p, input logic [15:0] c);
        @(negedge clk);
        in_ttl = t; in_proto = p; in_csum = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_ttl = '0; in_proto = '0; in_csum = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 out_valid in reset", {31'h0, out_valid}, 32'h0);
        chk(in_ready == 1'b1, "R8 in_ready in reset", {31'h0, in_ready}, 32'h1);
        rst_n = 1'b1;

        // Table walk: every result against a full header recomputation (R1 R2 R4 R5 R7)
        for (int i = 0; i < 10; i++) begin
            logic [7:0]  t, p;
            logic [15:0] sd, c_in, c_exp;
            logic        ex;
            t = VEC[i][31:24]; p = VEC[i][23:16]; sd = VEC[i][15:0];
            c_in = full_csum(t, p, sd);
            ex   = (t <= 8'd1);
            c_exp = ex ? c_in : full_csum(t - 8'd1, p, sd);
            send(t, p, c_in);
            chk(out_valid == 1'b1, "R7 result valid", {31'h0, out_valid}, 32'h1);
            chk(out_ttl == (ex ? t : t - 8'd1), ex ? "R4 ttl unchanged" : "R1 ttl decrement",
                {24'h0, out_ttl}, {24'h0, ex ? t : t - 8'd1});
            chk(out_csum == c_exp, ex ? "R4 csum unchanged" : "R2 csum recompute",
                {16'h0, out_csum}, {16'h0, c_exp});
            chk(out_expired == ex, "R4 expired flag", {31'h0, out_expired}, {31'h0, ex});
            chk(out_proto == p, "R5 proto kept", {24'h0, out_proto}, {24'h0, p});
        end

        // R3 end-around carry corners
        send(8'h40, 8'h06, 16'h0000);
        chk(out_csum == 16'h0100, "R3 fold 0000", {16'h0, out_csum}, 32'h0100);
        send(8'h40, 8'h06, 16'h0100);
        chk(out_csum == 16'h0200, "R3 fold 0100", {16'h0, out_csum}, 32'h0200);
        send(8'h40, 8'h06, 16'h00ff);
        chk(out_csum == 16'h01ff, "R3 fold 00ff", {16'h0, out_csum}, 32'h01ff);
        send(8'h40, 8'h06, 16'hff00);
        chk(out_csum == 16'h0001, "R3 no carry ff00", {16'h0, out_csum}, 32'h0001);

        // R6 stall hold, then R7 single hand-off
        @(negedge clk);
        out_ready = 1'b0;
        in_ttl = 8'h20; in_proto = 8'h11; in_csum = 16'h1000; in_valid = 1'b1;
        @(negedge clk);
        in_ttl = 8'h30; in_proto = 8'h06; in_csum = 16'h2000;
        @(negedge clk);
        chk(out_ttl == 8'h1f, "R6 ttl held", {24'h0, out_ttl}, 32'h1f);
        chk(out_csum == 16'h1100, "R6 csum held", {16'h0, out_csum}, 32'h1100);
        chk(in_ready == 1'b0, "R6 in_ready low", {31'h0, in_ready}, 32'h0);
        chk(out_valid == 1'b1, "R6 valid held", {31'h0, out_valid}, 32'h1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_ttl == 8'h2f && out_valid, "R7 next result", {24'h0, out_ttl}, 32'h2f);
        chk(out_csum == 16'h2100, "R2 next csum", {16'h0, out_csum}, 32'h2100);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 one result per accept", {31'h0, out_valid}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule